// File: doc/BRIEF.md
# Dual-Reference Duty-Cycle Compensation Controller

The block drives a frequency-locked timer loop that alternates between two reference resistors with opposite temperature coefficients. Time is divided into averaging windows counted in loop-update ticks. Each window first holds the loop on the positive-coefficient reference for a programmable number of ticks, then on the negative-coefficient reference for a second programmable number of ticks. The ratio of the two counts sets the averaged frequency, which cancels the temperature drift of the two resistors against each other.

While it does this, the block records the loop's tuning word at the last tick of each segment, once the loop has settled in that mode. Downstream logic divides the two words to get a temperature reading that does not depend on the oscillator gain. The capture is passive and never changes the reference selection.

The two captured words form a valid-only output stream with no back-pressure. `cap_valid` pulses for one clock when a window has produced a fresh pair. Both words then stay stable until the next capture point of a later window, and a consumer may read them at any time in that interval.

Top module: `dref_pwm_ctrl`

## Requirements
- R1: `sel_p` is 1 while the positive-coefficient segment runs and 0 otherwise. Within a window the positive segment always comes before the negative segment.
- R2: A segment lasts exactly as many `tick` pulses as its code value. `sel_p` changes only on the clock edge that takes a tick, except when leaving the idle state.
- R3: Codes are `CODE_W` bits wide (13 by default). The largest code, 2^CODE_W-1, gives a segment of that many ticks.
- R4: `tw_p` takes `tw_in` on the last tick of a positive segment, and `tw_n` takes `tw_in` on the last tick of a negative segment. Neither changes at any other time, whatever `tw_in` does between ticks.
- R5: `code_p` and `code_n` are sampled only at a window boundary: on the last tick of a window, or on any clock while idle. A change in the middle of a window has no effect on that window.
- R6: A zero code skips its segment for the whole window. If both codes are zero the block is idle: `sel_p` is 0, ticks are ignored and nothing is captured.
- R7: `cap_valid` is 1 for exactly the one clock after the last tick of a negative segment, and only if the same window also ran a positive segment.
- R8: After reset `sel_p`, `tw_p`, `tw_n` and `cap_valid` are all 0 and the block is idle. It leaves idle on the first clock with a nonzero code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-clock strobe for each loop update |
| code_p | input | CODE_W | Length of the positive-coefficient segment, in ticks |
| code_n | input | CODE_W | Length of the negative-coefficient segment, in ticks |
| tw_in | input | TW_W | Tuning word currently applied by the loop |
| sel_p | output | 1 | Reference select: 1 = positive-coefficient, 0 = negative-coefficient |
| tw_p | output | TW_W | Tuning word captured in the positive segment |
| tw_n | output | TW_W | Tuning word captured in the negative segment |
| cap_valid | output | 1 | One-clock pulse when a fresh pair of tuning words is available |

## Verification
The bench builds the block with `CODE_W` = 6 and `TW_W` = 10. With these values a full-scale window of 63 plus 63 ticks fits in a few hundred clocks, so the largest-code boundary of R3 is exercised directly rather than by extrapolation. The small code width also lets the bench run windows with a single tick per segment, with one segment empty, and with both segments empty, back to back. New codes are applied in the middle of every window, so the boundary-only loading of R5 is checked on each window.

// File: rtl/dref_pkg.sv
package dref_pkg;
  // Which reference the loop is currently locked to.
  typedef enum logic [1:0] {
    SEG_IDLE = 2'd0,
    SEG_P    = 2'd1,
    SEG_N    = 2'd2
  } seg_e;
endpackage

// File: rtl/dref_seg_counter.sv
// Counts loop-update ticks inside the current segment and flags its last tick.
module dref_seg_counter #(
  parameter int CODE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              clr_i,
  input  logic [CODE_W-1:0] len_i,
  output logic              last_o
);
  logic [CODE_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = tick_i && (len_i != '0) && (cnt_q == len_i - 1'b1);

  // R2: the count never passes the length of the running segment
  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (len_i != '0) |-> (cnt_q < len_i));

  // R2: once the last tick has been taken, the count restarts
  p_restart_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (cnt_q == '0));
endmodule

// File: rtl/dref_window_fsm.sv
// Sequences the positive and negative segments of each averaging window.
module dref_window_fsm
  import dref_pkg::*;
#(
  parameter int CODE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] code_p_i,
  input  logic [CODE_W-1:0] code_n_i,
  input  logic              last_i,
  output logic              clr_o,
  output logic [CODE_W-1:0] len_o,
  output logic              sel_p_o,
  output logic              p_end_o,
  output logic              n_end_o,
  output logic              win_has_p_o
);
  seg_e              seg_q;
  seg_e              first_seg;
  logic [CODE_W-1:0] act_p_q, act_n_q;
  logic              win_end;

  // First segment of a window that starts from the live codes.
  always_comb begin
    if (code_p_i != '0)      first_seg = SEG_P;
    else if (code_n_i != '0) first_seg = SEG_N;
    else                     first_seg = SEG_IDLE;
  end

  // The window closes on its last tick, or every clock while idle.
  always_comb begin
    win_end = 1'b0;
    case (seg_q)
      SEG_IDLE: win_end = 1'b1;
      SEG_P:    win_end = last_i && (act_n_q == '0);
      SEG_N:    win_end = last_i;
      default:  win_end = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q   <= SEG_IDLE;
      act_p_q <= '0;
      act_n_q <= '0;
    end else if (win_end) begin
      seg_q   <= first_seg;
      act_p_q <= code_p_i;
      act_n_q <= code_n_i;
    end else if (seg_q == SEG_P && last_i) begin
      seg_q <= SEG_N;
    end
  end

  assign clr_o       = (seg_q == SEG_IDLE) || last_i;
  assign len_o       = (seg_q == SEG_P) ? act_p_q :
                       (seg_q == SEG_N) ? act_n_q : '0;
  assign sel_p_o     = (seg_q == SEG_P);
  assign p_end_o     = (seg_q == SEG_P) && last_i;
  assign n_end_o     = (seg_q == SEG_N) && last_i;
  assign win_has_p_o = (act_p_q != '0);

  // R1: a positive segment with a nonzero partner hands over to the negative one
  p_p_then_n_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_P && last_i && act_n_q != '0) |=> (seg_q == SEG_N));

  // R2: without a tick a running segment holds
  p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && seg_q != SEG_IDLE) |=> $stable(seg_q));

  // R5: active codes stay fixed inside a window
  p_codes_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q != SEG_IDLE && !last_i) |=> ($stable(act_p_q) && $stable(act_n_q)));

  // R6: a segment with a zero length is never entered
  p_no_empty_seg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q != SEG_IDLE) |-> (len_o != '0));
endmodule

// File: rtl/dref_tw_capture.sv
// Holds the tuning word settled in each mode and flags a complete pair.
module dref_tw_capture #(
  parameter int TW_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TW_W-1:0] tw_i,
  input  logic            p_end_i,
  input  logic            n_end_i,
  input  logic            win_has_p_i,
  output logic [TW_W-1:0] tw_p_o,
  output logic [TW_W-1:0] tw_n_o,
  output logic            valid_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tw_p_o  <= '0;
      tw_n_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      if (p_end_i) tw_p_o <= tw_i;
      if (n_end_i) tw_n_o <= tw_i;
      valid_o <= n_end_i && win_has_p_i;
    end
  end

  // R7: the pair flag is a single-clock pulse
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R7: the flag follows the close of a negative segment
  p_valid_after_n_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(n_end_i));

  // R4: the negative word moves only at a negative capture point
  p_tw_n_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !n_end_i |=> $stable(tw_n_o));

  // R4: the positive word moves only at a positive capture point
  p_tw_p_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !p_end_i |=> $stable(tw_p_o));
endmodule

// File: rtl/dref_pwm_ctrl.sv
// Top: time-interleaves two references and records the tuning word in each mode.
module dref_pwm_ctrl #(
  parameter int CODE_W = 13,
  parameter int TW_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CODE_W-1:0] code_p,
  input  logic [CODE_W-1:0] code_n,
  input  logic [TW_W-1:0]   tw_in,
  output logic              sel_p,
  output logic [TW_W-1:0]   tw_p,
  output logic [TW_W-1:0]   tw_n,
  output logic              cap_valid
);
  logic              seg_last;
  logic              seg_clr;
  logic [CODE_W-1:0] seg_len;
  logic              p_end, n_end, win_has_p;

  dref_seg_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .clr_i  (seg_clr),
    .len_i  (seg_len),
    .last_o (seg_last)
  );

  dref_window_fsm #(.CODE_W(CODE_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .code_p_i    (code_p),
    .code_n_i    (code_n),
    .last_i      (seg_last),
    .clr_o       (seg_clr),
    .len_o       (seg_len),
    .sel_p_o     (sel_p),
    .p_end_o     (p_end),
    .n_end_o     (n_end),
    .win_has_p_o (win_has_p)
  );

  dref_tw_capture #(.TW_W(TW_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .tw_i        (tw_in),
    .p_end_i     (p_end),
    .n_end_i     (n_end),
    .win_has_p_i (win_has_p),
    .tw_p_o      (tw_p),
    .tw_n_o      (tw_n),
    .valid_o     (cap_valid)
  );

  // R6: the select is never high during a capture of the negative word
  p_sel_low_on_n_r6: assert property (@(posedge clk) disable iff (!rst_n)
    n_end |-> !sel_p);
endmodule

// File: tb/dref_pwm_ctrl_tb.sv
module dref_pwm_ctrl_tb;
  localparam int CW = 6;
  localparam int TW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [CW-1:0] code_p = '0;
  logic [CW-1:0] code_n = '0;
  logic [TW-1:0] tw_in = '0;
  logic          sel_p, cap_valid;
  logic [TW-1:0] tw_p, tw_n;

  int n_chk = 0;
  int n_bad = 0;
  logic [TW-1:0] exp_tw_p = '0;
  logic [TW-1:0] exp_tw_n = '0;

  always #4 clk = ~clk;

  dref_pwm_ctrl #(.CODE_W(CW), .TW_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .code_p(code_p), .code_n(code_n),
    .tw_in(tw_in), .sel_p(sel_p), .tw_p(tw_p), .tw_n(tw_n), .cap_valid(cap_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One tick pulse carrying a tuning word; returns at the negedge after the edge.
  task automatic pulse(input logic [TW-1:0] v);
    tw_in = v;
    tick  = 1'b1;
    @(negedge clk);
    tick  = 1'b0;
    tw_in = 10'd999;
  endtask

  // Runs one window of p then n ticks; new codes are applied after the first tick.
  task automatic run_window(input int p, input int n, input int np, input int nn);
    int first = 1;
    for (int i = 0; i < p; i++) begin
      check("R1 sel high in P segment", sel_p, 1);
      pulse(10'(100 + i));
      if (first) begin code_p = CW'(np); code_n = CW'(nn); first = 0; end
      if (i == p - 1) begin
        exp_tw_p = 10'(100 + i);
        check("R4 tw_p captured at last P tick", tw_p, exp_tw_p);
      end else begin
        check("R4 tw_p steady inside P", tw_p, exp_tw_p);
      end
      @(negedge clk);
      check("R2 sel holds between ticks", sel_p, (i == p - 1) ? ((n != 0) ? 0 : (np != 0 ? 1 : 0)) : 1);
    end
    for (int j = 0; j < n; j++) begin
      check("R1 sel low in N segment", sel_p, 0);
      pulse(10'(500 + j));
      if (first) begin code_p = CW'(np); code_n = CW'(nn); first = 0; end
      if (j == n - 1) begin
        exp_tw_n = 10'(500 + j);
        check("R4 tw_n captured at last N tick", tw_n, exp_tw_n);
        check("R7 cap_valid after last N tick", cap_valid, (p != 0) ? 1 : 0);
      end else begin
        check("R4 tw_n steady inside N", tw_n, exp_tw_n);
        check("R7 no cap_valid mid window", cap_valid, 0);
      end
      @(negedge clk);
      check("R7 cap_valid lasts one clock", cap_valid, 0);
    end
    if (n == 0) begin
      check("R6 no cap_valid without N segment", cap_valid, 0);
      check("R6 tw_n unchanged without N segment", tw_n, exp_tw_n);
    end
    check("R4 tw_p held after window", tw_p, exp_tw_p);
  endtask

  task automatic t_reset();
    check("R8 sel_p after reset", sel_p, 0);
    check("R8 tw_p after reset", tw_p, 0);
    check("R8 tw_n after reset", tw_n, 0);
    check("R8 cap_valid after reset", cap_valid, 0);
    pulse(10'd7);
    @(negedge clk);
    check("R6 idle ignores tick", sel_p, 0);
    check("R6 idle captures nothing", tw_p, 0);
  endtask

  task automatic t_idle();
    for (int k = 0; k < 4; k++) begin
      pulse(10'(300 + k));
      check("R6 idle sel low", sel_p, 0);
      check("R6 idle no valid", cap_valid, 0);
      check("R6 idle tw_p unchanged", tw_p, exp_tw_p);
      check("R6 idle tw_n unchanged", tw_n, exp_tw_n);
      @(negedge clk);
    end
    code_p = 6'd2; code_n = 6'd2;
    @(negedge clk);
    check("R8 leaves idle on nonzero code", sel_p, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    code_p = 6'd3; code_n = 6'd2;
    @(negedge clk);
    run_window(3, 2, 1, 4);    // R1 R2 R4 R5 R7
    run_window(1, 4, 0, 3);    // single-tick P segment
    run_window(0, 3, 5, 0);    // R6 P skipped
    run_window(5, 0, 63, 63);  // R6 N skipped
    run_window(63, 63, 0, 0);  // R3 full-scale codes
    t_idle();
    run_window(2, 2, 2, 2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule